// File: doc/BRIEF.md
# Single-Slot Command Issue Sequencer

This block is a bus master that runs one non-queued storage command on one port of a host controller. The controller's registers are reached only through an index/data pair: the sequencer first writes a register's absolute offset to the index location, then reads or writes the data location. A request carries the port number, a write flag, a packet-command flag, the length of the host-to-device frame in dwords and the transfer byte count.

After it accepts a request, the sequencer builds the three dwords of the slot-0 command header and shows them for one cycle to a memory writer. It then drives the handshake. It sets the port's start bit with a read-modify-write and writes 1 to the command-issue register. It reads interrupt status until the bit that reports the device-to-host frame is set, writes that status back to acknowledge it, and clears the start bit with a second read-modify-write. A one-cycle done pulse ends the command. A port value of all ones means that no port is selected. Such a request finishes at once and makes no register access. If the status bit never appears, a poll limit ends the wait, the start bit is still cleared, and done is flagged with a timeout.

Top module: `cmd_issue_seq`

## Requirements
- R1: One cycle after a request with a valid port is accepted, `hdr_valid` is high for exactly one cycle. In that cycle `hdr_dw0` has bit 16 and bit 7 set, bit 6 equal to the write flag, bit 5 equal to the packet flag, bits 4:0 equal to the frame length, and all other bits zero.
- R2: In the same cycle `hdr_dw1` equals the byte count, zero-extended, and `hdr_dw2` equals the parameter `TBL_ADDR`.
- R3: The first register operation sets the start bit (bit 0) of the port command register at offset 0x18. It writes the index, reads data, and writes back the value read OR 1, so every other bit is kept.
- R4: The next operation writes the index of the command-issue register (offset 0x38) and then writes the value 1 to data.
- R5: Next comes an index write of interrupt status (offset 0x10) and then data reads that repeat until a read returns bit 0 set. The sequencer then writes the index again, reads, and writes back the value read OR 1.
- R6: The last operation writes the command register index, reads, and writes back the value read with bit 0 cleared. `done` is then high for one cycle.
- R7: A request with port 0xFF raises `done` and `rejected` in the next cycle. It produces no bus access and no header pulse.
- R8: If the status bit stays clear for `POLL_LIMIT` consecutive reads, the poll stops without an acknowledge. The start bit is cleared as in R6, and `done` comes with `timed_out` high.
- R9: `busy` is high from the cycle after acceptance until `done`. A request presented while busy is ignored.
- R10: Each index write carries 0x100 + port*0x80 + register offset. A bus request holds `rb_valid` and its data stable until `rb_ready`. `rb_sel` is 0 for the index location and 1 for the data location.
- R11: After reset `busy`, `done` and `rb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_port | input | 8 | Port number, 0xFF means none |
| req_write | input | 1 | Command writes to the device |
| req_packet | input | 1 | Packet (ATAPI) command |
| req_fis_dw | input | 5 | Frame length in dwords |
| req_bytes | input | 16 | Transfer byte count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | With done: port was 0xFF |
| timed_out | output | 1 | With done: poll limit reached |
| hdr_valid | output | 1 | Header dwords valid this cycle |
| hdr_dw0 | output | 32 | Header flags and frame length |
| hdr_dw1 | output | 32 | Header byte count |
| hdr_dw2 | output | 32 | Header command table address |
| rb_valid | output | 1 | Register bus request |
| rb_sel | output | 1 | 0 index location, 1 data location |
| rb_we | output | 1 | 1 write, 0 read |
| rb_wdata | output | 32 | Write data or index value |
| rb_ready | input | 1 | Register bus acknowledge |
| rb_rdata | input | 32 | Read data, valid with rb_ready |

## Verification
The bench sweeps several ports, all four write/packet flag combinations, and poll delays from zero to several reads, with a bus that inserts wait states and one that never does. It compares every bus transfer against a trace computed from the requirements. A design that wrote a constant instead of merging would lose the other command bits. One that skipped the index rewrite before the acknowledge, or polled one read too few or too many, would show a shorter or longer trace. Further cases cover the rejected port, which must give no access at all, and a device that never answers, which must time out after exactly the limit with no acknowledge. A request during busy must not restart or double the completion.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_IDX, S_RD, S_WR, S_FIN
  } cis_state_e;

  typedef enum logic [2:0] {
    OP_START, OP_ISSUE, OP_POLL, OP_ACK, OP_STOP
  } cis_op_e;

  localparam logic [31:0] OFF_CMD   = 32'h18;
  localparam logic [31:0] OFF_ISSUE = 32'h38;
  localparam logic [31:0] OFF_STAT  = 32'h10;
  localparam int          BIT_RUN   = 0;
  localparam int          BIT_D2H   = 0;
endpackage

// File: rtl/cis_hdr_build.sv
module cis_hdr_build #(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 5,
  parameter int CNT_W    = 16,
  parameter logic [31:0] TBL_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wr,
  input  logic              pkt,
  input  logic [LEN_W-1:0]  fis_dw,
  input  logic [CNT_W-1:0]  bytes,
  output logic [DATA_W-1:0] dw0,
  output logic [DATA_W-1:0] dw1,
  output logic [DATA_W-1:0] dw2
);
  localparam int PRD_ONE_BIT = 16;
  localparam int CLR_BSY_BIT = 7;
  localparam int WRITE_BIT   = 6;
  localparam int PKT_BIT     = 5;

  logic [DATA_W-1:0] flags;

  always_comb begin
    flags = '0;
    flags[PRD_ONE_BIT] = 1'b1;
    flags[CLR_BSY_BIT] = 1'b1;
    flags[WRITE_BIT]   = wr;
    flags[PKT_BIT]     = pkt;
    flags[LEN_W-1:0]   = fis_dw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dw0 <= '0;
      dw1 <= '0;
      dw2 <= '0;
    end else if (load) begin
      dw0 <= flags;
      dw1 <= DATA_W'(bytes);
      dw2 <= DATA_W'(TBL_ADDR);
    end
  end
endmodule

// File: rtl/cis_poll_timer.sv
module cis_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/cmd_issue_seq.sv
module cmd_issue_seq
  import cis_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PORT_W      = 8,
  parameter int LEN_W       = 5,
  parameter int CNT_W       = 16,
  parameter int POLL_LIMIT  = 1000,
  parameter logic [31:0] HBA_BASE    = 32'h100,
  parameter logic [31:0] PORT_STRIDE = 32'h80,
  parameter logic [31:0] TBL_ADDR    = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_write,
  input  logic              req_packet,
  input  logic [LEN_W-1:0]  req_fis_dw,
  input  logic [CNT_W-1:0]  req_bytes,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic              timed_out,
  output logic              hdr_valid,
  output logic [DATA_W-1:0] hdr_dw0,
  output logic [DATA_W-1:0] hdr_dw1,
  output logic [DATA_W-1:0] hdr_dw2,
  output logic              rb_valid,
  output logic              rb_sel,
  output logic              rb_we,
  output logic [DATA_W-1:0] rb_wdata,
  input  logic              rb_ready,
  input  logic [DATA_W-1:0] rb_rdata
);
  localparam logic [PORT_W-1:0] NO_PORT = '1;

  cis_state_e        st;
  cis_op_e           op;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] rv;
  logic              rej_q, tmo_q, tmo_last;
  logic [DATA_W-1:0] reg_off, idx_val;
  logic              accept, poll_miss;

  assign accept    = (st == S_IDLE) && req_valid;
  assign poll_miss = (st == S_RD) && (op == OP_POLL) && rb_ready && !rb_rdata[BIT_D2H];

  cis_hdr_build #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .TBL_ADDR(TBL_ADDR)
  ) u_hdr (
    .clk(clk), .rst(rst),
    .load(accept && (req_port != NO_PORT)),
    .wr(req_write), .pkt(req_packet), .fis_dw(req_fis_dw), .bytes(req_bytes),
    .dw0(hdr_dw0), .dw1(hdr_dw1), .dw2(hdr_dw2)
  );

  cis_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst(rst), .clr(st == S_HDR), .step(poll_miss), .last(tmo_last)
  );

  always_comb begin
    case (op)
      OP_ISSUE:        reg_off = OFF_ISSUE;
      OP_POLL, OP_ACK: reg_off = OFF_STAT;
      default:         reg_off = OFF_CMD;
    endcase
    idx_val = DATA_W'(HBA_BASE) + DATA_W'(port_q) * DATA_W'(PORT_STRIDE) + reg_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      op     <= OP_START;
      port_q <= '0;
      rv     <= '0;
      rej_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          port_q <= req_port;
          rej_q  <= (req_port == NO_PORT);
          tmo_q  <= 1'b0;
          op     <= OP_START;
          st     <= (req_port == NO_PORT) ? S_FIN : S_HDR;
        end
        S_HDR: st <= S_IDX;
        S_IDX: if (rb_ready) st <= (op == OP_ISSUE) ? S_WR : S_RD;
        S_RD: if (rb_ready) begin
          rv <= rb_rdata;
          if (op == OP_POLL) begin
            if (rb_rdata[BIT_D2H]) begin
              op <= OP_ACK;
              st <= S_IDX;
            end else if (tmo_last) begin
              tmo_q <= 1'b1;
              op    <= OP_STOP;
              st    <= S_IDX;
            end
          end else begin
            st <= S_WR;
          end
        end
        S_WR: if (rb_ready) begin
          case (op)
            OP_START: begin op <= OP_ISSUE; st <= S_IDX; end
            OP_ISSUE: begin op <= OP_POLL;  st <= S_IDX; end
            OP_ACK:   begin op <= OP_STOP;  st <= S_IDX; end
            default:  st <= S_FIN;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rb_valid = (st == S_IDX) || (st == S_RD) || (st == S_WR);
    rb_sel   = (st != S_IDX);
    rb_we    = (st != S_RD);
    rb_wdata = '0;
    if (st == S_IDX) rb_wdata = idx_val;
    else if (st == S_WR) begin
      case (op)
        OP_ISSUE: rb_wdata = DATA_W'(1);
        OP_STOP:  begin rb_wdata = rv; rb_wdata[BIT_RUN] = 1'b0; end
        default:  begin rb_wdata = rv; rb_wdata[BIT_RUN] = 1'b1; end
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign rejected  = done && rej_q;
  assign timed_out = done && tmo_q;
  assign hdr_valid = (st == S_HDR);

  // R10: a request stays posted, with its payload unchanged, until acknowledged
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_wdata) && $stable(rb_sel) && $stable(rb_we)));

  // R7: an empty port finishes in the next cycle
  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_port == NO_PORT) |=> (done && rejected && !hdr_valid));

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the timer's last miss turns the sequence to the stop operation
  p_tmo_r8: assert property (@(posedge clk) disable iff (rst)
    (poll_miss && tmo_last) |=> (op == OP_STOP && st == S_IDX));

  // R1: the header pulse carries the fixed flag bits from the builder
  p_hdr_r1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (hdr_dw0[16] && hdr_dw0[7] && !hdr_dw0[15]));

  // R9: a busy sequencer never posts a new header on a fresh request
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> !hdr_valid || $past(st == S_IDLE));
endmodule

// File: tb/sim_cmd_issue_seq.sv
module sim_cmd_issue_seq;
  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_port = '0;
  logic        req_write = 1'b0, req_packet = 1'b0;
  logic [4:0]  req_fis_dw = '0;
  logic [15:0] req_bytes = '0;
  logic        busy, done, rejected, timed_out, hdr_valid;
  logic [31:0] hdr_dw0, hdr_dw1, hdr_dw2;
  logic        rb_valid, rb_sel, rb_we;
  logic [31:0] rb_wdata, rb_rdata;
  logic        rb_ready = 1'b0;

  always #10 clk = ~clk;

  cmd_issue_seq #(.POLL_LIMIT(LIM), .TBL_ADDR(32'h0002_3400)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_write(req_write), .req_packet(req_packet), .req_fis_dw(req_fis_dw),
    .req_bytes(req_bytes), .busy(busy), .done(done), .rejected(rejected),
    .timed_out(timed_out), .hdr_valid(hdr_valid), .hdr_dw0(hdr_dw0),
    .hdr_dw1(hdr_dw1), .hdr_dw2(hdr_dw2), .rb_valid(rb_valid), .rb_sel(rb_sel),
    .rb_we(rb_we), .rb_wdata(rb_wdata), .rb_ready(rb_ready), .rb_rdata(rb_rdata)
  );

  int errors = 0, checks = 0, cyc = 0;
  int slow_bus = 0;

  // register model
  logic [31:0] m_idx, m_cmd, m_is, m_ci;
  logic        m_armed;
  int          m_polls, m_k;
  logic        ld = 1'b0;
  logic [31:0] ld_cmd, ld_is;
  int          ld_k;
  // trace
  logic [33:0] tr [64];
  int          tr_n, done_cnt, hdr_seen;
  logic [31:0] cap0, cap1, cap2;

  always_comb begin
    case (m_idx[6:0])
      7'h18:   rb_rdata = m_cmd;
      7'h38:   rb_rdata = m_ci;
      7'h10:   rb_rdata = m_is | {31'b0, (m_armed && m_polls >= m_k)};
      default: rb_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (hdr_valid) begin
      cap0 <= hdr_dw0; cap1 <= hdr_dw1; cap2 <= hdr_dw2; hdr_seen <= hdr_seen + 1;
    end
    if (ld) begin
      m_cmd <= ld_cmd; m_is <= ld_is; m_k <= ld_k; m_ci <= 0;
      m_armed <= 1'b0; m_polls <= 0; m_idx <= 0; tr_n <= 0;
    end else if (rb_valid && rb_ready) begin
      if (tr_n < 64) tr[tr_n] <= {rb_sel, rb_we, rb_we ? rb_wdata : 32'h0};
      tr_n <= tr_n + 1;
      if (!rb_sel) m_idx <= rb_wdata;
      else if (rb_we) begin
        case (m_idx[6:0])
          7'h18: m_cmd <= rb_wdata;
          7'h38: begin m_ci <= rb_wdata; m_armed <= 1'b1; m_polls <= 0; end
          7'h10: begin m_is <= m_is & ~rb_wdata; m_armed <= 1'b0; end
          default: ;
        endcase
      end else if (m_idx[6:0] == 7'h10) begin
        if (m_armed && m_polls >= m_k) m_is <= m_is | 32'h1;
        m_polls <= m_polls + 1;
      end
    end
  end

  always @(negedge clk) rb_ready <= (slow_bus == 0) ? 1'b1 : ((cyc % 3) != 1);

  always @(negedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected trace
  logic [33:0] ex [64];
  int ex_n;
  task automatic push(input logic s, input logic w, input logic [31:0] d);
    ex[ex_n] = {s, w, d};
    ex_n = ex_n + 1;
  endtask

  task automatic run(input logic [7:0] p, input logic w, input logic k_pkt,
                     input logic [4:0] fl, input logic [15:0] by,
                     input logic [31:0] c0, input logic [31:0] i0, input int k,
                     input bit poke_busy);
    logic [31:0] base;
    int polls;
    bit tmo;
    int d0, h0, wait_c;
    bit same;
    logic [31:0] e0;
    base = 32'h100 + 32'(p) * 32'h80;
    tmo = (k >= LIM);
    polls = tmo ? LIM : k + 1;
    ex_n = 0;
    push(0, 1, base + 32'h18); push(1, 0, 0); push(1, 1, c0 | 32'h1);
    push(0, 1, base + 32'h38); push(1, 1, 32'h1);
    push(0, 1, base + 32'h10);
    for (int i = 0; i < polls; i++) push(1, 0, 0);
    if (!tmo) begin
      push(0, 1, base + 32'h10); push(1, 0, 0); push(1, 1, i0 | 32'h1);
    end
    push(0, 1, base + 32'h18); push(1, 0, 0); push(1, 1, c0 & ~32'h1);

    @(negedge clk);
    ld_cmd = c0; ld_is = i0; ld_k = k; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
    d0 = done_cnt; h0 = hdr_seen;
    req_port = p; req_write = w; req_packet = k_pkt; req_fis_dw = fl; req_bytes = by;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", {31'b0, busy}, 32'h1);
    if (poke_busy) begin
      @(negedge clk);
      req_port = p ^ 8'h03; req_write = ~w; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_c = 0;
    while (done_cnt == d0 && wait_c < 2000) begin @(negedge clk); wait_c++; end
    if (done_cnt == d0) @(negedge clk);
    // done was high on the last edge; flags were valid with it
    e0 = 32'h0001_0080 | (32'(w) << 6) | (32'(k_pkt) << 5) | 32'(fl);
    chk(hdr_seen == h0 + 1, "R1", "header pulse count", 32'(hdr_seen - h0), 32'h1);
    chk(cap0 == e0, "R1", "hdr_dw0", cap0, e0);
    chk(cap1 == 32'(by), "R2", "hdr_dw1", cap1, 32'(by));
    chk(cap2 == 32'h0002_3400, "R2", "hdr_dw2", cap2, 32'h0002_3400);
    same = (tr_n == ex_n);
    for (int i = 0; i < ex_n && i < 64; i++) if (tr[i] != ex[i]) same = 1'b0;
    chk(same, tmo ? "R8" : "R5", "bus trace (R3 R4 R6 R10)", 32'(tr_n), 32'(ex_n));
    chk(m_cmd == (c0 & ~32'h1), "R6", "command reg after stop", m_cmd, c0 & ~32'h1);
    chk(m_ci == 32'h1, "R4", "issue reg", m_ci, 32'h1);
    chk(m_is == (tmo ? i0 : 32'h0), tmo ? "R8" : "R5", "status after ack", m_is,
        tmo ? i0 : 32'h0);
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1 && !busy, "R9", "single completion", 32'(done_cnt - d0), 32'h1);
  endtask

  // capture flags at the done edge
  logic last_tmo, last_rej;
  always @(posedge clk) if (done) begin last_tmo <= timed_out; last_rej <= rejected; end

  initial begin
    tr_n = 0; done_cnt = 0; hdr_seen = 0; m_k = 0; m_polls = 0; m_armed = 1'b0;
    m_idx = 0; m_cmd = 0; m_is = 0; m_ci = 0; ld_cmd = 0; ld_is = 0; ld_k = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rb_valid, "R11", "reset state",
        {29'b0, busy, done, rb_valid}, 32'h0);

    for (int sb = 0; sb < 2; sb++) begin
      slow_bus = sb;
      for (int f = 0; f < 4; f++) begin
        for (int kk = 0; kk < 4; kk++) begin
          logic [7:0] pp;
          int kv;
          pp = (kk == 0) ? 8'd0 : (kk == 1) ? 8'd1 : (kk == 2) ? 8'd5 : 8'd31;
          kv = (kk == 3) ? 7 : kk;
          run(pp, f[0], f[1], 5'(5 + f), 16'(512 * (kk + 1) + f),
              32'h0000_0010 | 32'(f << 8), 32'(kk << 4), kv, 1'b0);
          chk(last_tmo == 1'b0 && last_rej == 1'b0, "R8", "no timeout flag",
              {30'b0, last_tmo, last_rej}, 32'h0);
        end
      end
    end

    // device never answers
    run(8'd2, 1'b0, 1'b0, 5'd5, 16'd512, 32'h0000_4011, 32'h0000_0040, 1000, 1'b0);
    chk(last_tmo == 1'b1, "R8", "timeout flag", {31'b0, last_tmo}, 32'h1);

    // request during busy is ignored
    slow_bus = 1;
    run(8'd7, 1'b1, 1'b0, 5'd5, 16'd4096, 32'h0000_0010, 32'h0, 3, 1'b1);

    // empty port
    begin
      int d0, h0, n0;
      @(negedge clk);
      ld_cmd = 32'h0; ld_is = 32'h0; ld_k = 0; ld = 1'b1;
      @(negedge clk);
      ld = 1'b0;
      d0 = done_cnt; h0 = hdr_seen; n0 = tr_n;
      req_port = 8'hFF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(done && rejected, "R7", "done+rejected next cycle", {30'b0, done, rejected}, 32'h3);
      repeat (5) @(negedge clk);
      chk(tr_n == n0 && hdr_seen == h0, "R7", "no bus access or header",
          32'(tr_n - n0 + hdr_seen - h0), 32'h0);
      chk(done_cnt == d0 + 1, "R7", "single done", 32'(done_cnt - d0), 32'h1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule